// File: doc/BRIEF.md
# Triggered Modulo Timer Counter

This block is an up counter that counts from zero to a programmable modulo value and then wraps to zero. Each wrap raises a one-cycle overflow pulse and sets a sticky overflow flag. The counting clock comes from a 2-bit mode field. The field can disable the counter, choose the system clock, or choose an external clock. The external clock is sampled into the system clock domain and its rising edges are used as count enables. A power-of-two prescaler then divides whichever tick is selected.

One trigger is chosen from sixteen trigger lines, and its rising edge or its level controls the counter in several ways. The counter can wait for a trigger before it starts. It can return to zero on a trigger. It can hold while the trigger stays high. It can also halt after one overflow. Separate options freeze the counter while the chip is in a low-power doze state or in a debug halt. Software drives the block through a write-only register port with three addresses: control, modulo and status clear. The mode in effect is returned on a separate acknowledge output.

Top module: `trig_mod_timer`

## Requirements
- R1: The control word at address 0 holds the clock mode in bits [1:0]. Mode 0 (and the reserved mode 3) leaves the count unchanged. Mode 1 advances on every system clock. Mode 2 advances on external clock edges.
- R2: Control bits [4:2] hold an exponent N. The counter advances once per 2^N selected ticks, so 0 gives 1 and 7 gives 128.
- R3: The counter steps 0, 1, ..., M and then returns to 0, where M is the modulo written to address 1. On the cycle the count returns to 0, `ovf_pulse` is high for exactly one cycle.
- R4: In mode 2 the external clock passes through a two-stage synchronizer. Each rising edge gives exactly one tick. A steady external clock gives no ticks.
- R5: Control bits [8:5] select trigger line `trig_in[sel]`. A trigger event is a rising edge on that line. When the start-on-trigger option (bit 9) is set, the counter stays still after being enabled until a trigger event. It counts from the next cycle onward. Edges on lines that are not selected have no effect.
- R6: With reload-on-trigger (bit 10) set and the counter enabled, a trigger event sets the count to 0 and restarts the prescaler. It does not produce an overflow.
- R7: With pause-on-trigger (bit 12) set, the count holds for as long as the selected trigger line is high.
- R8: With stop-after-overflow (bit 11) set, the counter halts at 0 after its first wrap. It stays halted until it is disabled through mode 0, or, when start-on-trigger is set, until the next trigger event.
- R9: The count is frozen while `doze_mode` is high and bit 13 is set. It is also frozen while `dbg_mode` is high and bit 14 (run in debug) is clear.
- R10: `ovf_flag` sets on every overflow and stays set. A write to address 2 with bit 8 set clears it. A write to address 2 with bit 8 clear leaves it unchanged. An overflow in the same cycle as a clear wins over the clear.
- R11: A modulo of 0 behaves as a modulo of 1.
- R12: `mode_ack` shows the mode in effect. It takes a newly written mode two clock edges after the write, so reading 0 there means counting has ceased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 modulo, 2 status clear |
| wr_data | input | 32 | Write data |
| ext_clk | input | 1 | External clock, asynchronous to clk |
| trig_in | input | 16 | Trigger source lines |
| dbg_mode | input | 1 | Chip is in debug halt |
| doze_mode | input | 1 | Chip is in doze |
| count | output | 16 | Current count |
| ovf_pulse | output | 1 | One-cycle overflow strobe |
| ovf_flag | output | 1 | Sticky overflow flag |
| mode_ack | output | 2 | Clock mode in effect |

## Verification
The hardest states to reach are those where several trigger options apply at once. Examples are a counter halted after overflow that must be released by a mode change, and a counter that has been enabled but is still waiting for its first trigger event. The stimulus reaches them by always passing through mode 0 between phases, which clears the armed and halted states. It then pulses a non-selected line before the selected one, and holds the selected line high across several clock edges for the pause case. A behavioural model in the bench follows every edge, so each intermediate count is compared, not only the end points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      CLK_OFF = 2'd0,
      CLK_SYS = 2'd1,
      CLK_EXT = 2'd2,
      CLK_RSV = 2'd3
   } clk_mode_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_MOD  = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   localparam int STAT_OVF_BIT = 8;
   localparam int OPT_BITS     = 6;

   // Packed with start_on as the least significant bit.
   typedef struct packed {
      logic dbg_run;
      logic doze_frz;
      logic pause_on;
      logic stop_on;
      logic reload_on;
      logic start_on;
   } opt_t;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 3,
   parameter int SEL_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output clk_mode_e         mode_req,
   output logic [PSC_W-1:0]  psc_sel,
   output logic [SEL_W-1:0]  trig_sel,
   output opt_t              opts,
   output logic [CNT_W-1:0]  modulo,
   output logic              flag_clr
);
   localparam int PSC_LSB = 2;
   localparam int SEL_LSB = PSC_LSB + PSC_W;
   localparam int OPT_LSB = SEL_LSB + SEL_W;

   logic wr_ctrl, wr_mod;
   logic unused_wr_bits;

   assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_mod   = wr_en && (wr_addr == ADDR_MOD);
   assign flag_clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[STAT_OVF_BIT];
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_req <= CLK_OFF;
         psc_sel  <= '0;
         trig_sel <= '0;
         opts     <= '0;
      end else if (wr_ctrl) begin
         mode_req <= clk_mode_e'(wr_data[1:0]);
         psc_sel  <= wr_data[SEL_LSB-1:PSC_LSB];
         trig_sel <= wr_data[OPT_LSB-1:SEL_LSB];
         opts     <= wr_data[OPT_LSB+OPT_BITS-1:OPT_LSB];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      modulo <= '0;
      else if (wr_mod) modulo <= wr_data[CNT_W-1:0];
   end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
   import tmr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ext_clk,
   input  clk_mode_e mode_req,
   output clk_mode_e mode_eff,
   output logic      active,
   output logic      tick
);
   logic [SYNC_STAGES:0] ext_sh;
   logic                 ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_sh[0] <= 1'b0;
      else        ext_sh[0] <= ext_clk;
   end

   for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_sh[g] <= 1'b0;
         else        ext_sh[g] <= ext_sh[g-1];
      end
   end

   assign ext_rise = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];

   // The mode in effect lags the request by one edge; this is also the acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_eff <= CLK_OFF;
      else        mode_eff <= mode_req;
   end

   always_comb begin
      unique case (mode_eff)
         CLK_SYS: tick = 1'b1;
         CLK_EXT: tick = ext_rise;
         default: tick = 1'b0;
      endcase
   end

   assign active = (mode_eff == CLK_SYS) || (mode_eff == CLK_EXT);

endmodule

// File: rtl/tmr_trig.sv
module tmr_trig #(
   parameter int TRIG_N = 16,
   parameter int SEL_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIG_N-1:0] trig_in,
   input  logic [SEL_W-1:0]  trig_sel,
   output logic              trig_lvl,
   output logic              trig_edge
);
   logic trig_prev;

   assign trig_lvl  = trig_in[trig_sel];
   assign trig_edge = trig_lvl & ~trig_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_prev <= 1'b0;
      else        trig_prev <= trig_lvl;
   end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PSC_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic [PSC_W-1:0] psc_sel,
   input  opt_t             opts,
   input  logic [CNT_W-1:0] modulo,
   input  logic             trig_lvl,
   input  logic             trig_edge,
   input  logic             dbg_mode,
   input  logic             doze_mode,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_pulse,
   output logic             ovf_flag
);
   localparam int PDIV_W = (1 << PSC_W) - 1;

   logic [PDIV_W-1:0] psc_cnt, psc_mask;
   logic [CNT_W-1:0]  mod_eff;
   logic psc_last, freeze, hold, armed, gate;
   logic reload_hit, step, wrap;
   logic started, halted;

   always_comb begin
      psc_mask = '0;
      for (int i = 0; i < PDIV_W; i++) psc_mask[i] = (i < int'(psc_sel));
   end

   assign psc_last   = (psc_cnt & psc_mask) == psc_mask;
   assign freeze     = (doze_mode & opts.doze_frz) | (dbg_mode & ~opts.dbg_run);
   assign hold       = opts.pause_on & trig_lvl;
   assign armed      = ~opts.start_on | started;
   assign gate       = armed & ~halted & ~freeze & ~hold;
   assign mod_eff    = (modulo == '0) ? CNT_W'(1) : modulo;
   assign reload_hit = active & opts.reload_on & trig_edge;
   assign step       = active & tick & gate & psc_last & ~reload_hit;
   assign wrap       = step & (count >= mod_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_cnt <= '0;
         started <= 1'b0;
         halted  <= 1'b0;
      end else if (!active) begin
         psc_cnt <= '0;
         started <= 1'b0;
         halted  <= 1'b0;
      end else begin
         if (reload_hit)       psc_cnt <= '0;
         else if (tick & gate) psc_cnt <= psc_last ? '0 : psc_cnt + 1'b1;
         if (trig_edge) started <= 1'b1;
         if (wrap & opts.stop_on)                 halted <= 1'b1;
         else if (trig_edge & opts.start_on)      halted <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          count <= '0;
      else if (reload_hit) count <= '0;
      else if (wrap)       count <= '0;
      else if (step)       count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_pulse <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         ovf_pulse <= wrap;
         if (wrap)          ovf_flag <= 1'b1;
         else if (flag_clr) ovf_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/trig_mod_timer.sv
module trig_mod_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 32,
   parameter int TRIG_N      = 16,
   parameter int PSC_W       = 3,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ext_clk,
   input  logic [TRIG_N-1:0] trig_in,
   input  logic              dbg_mode,
   input  logic              doze_mode,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_pulse,
   output logic              ovf_flag,
   output logic [1:0]        mode_ack
);
   localparam int SEL_W  = $clog2(TRIG_N);
   localparam int CTRL_W = 2 + PSC_W + SEL_W + OPT_BITS;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (TRIG_N < 2 || (1 << SEL_W) != TRIG_N) begin : g_bad_trig_n
      $error("TRIG_N must be a power of two, at least 2");
   end
   if (CTRL_W > DATA_W || DATA_W <= STAT_OVF_BIT) begin : g_bad_data_w
      $error("DATA_W too narrow for the control or status word");
   end
   if (PSC_W < 1 || PSC_W > 4) begin : g_bad_psc_w
      $error("PSC_W must lie between 1 and 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   clk_mode_e          mode_req, mode_eff;
   logic [PSC_W-1:0]   psc_sel;
   logic [SEL_W-1:0]   trig_sel;
   opt_t               opts;
   logic [CNT_W-1:0]   modulo;
   logic               flag_clr, active, tick, trig_lvl, trig_edge;

   tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .mode_req(mode_req), .psc_sel(psc_sel), .trig_sel(trig_sel), .opts(opts),
      .modulo(modulo), .flag_clr(flag_clr)
   );

   tmr_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
      .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .mode_req(mode_req),
      .mode_eff(mode_eff), .active(active), .tick(tick)
   );

   tmr_trig #(.TRIG_N(TRIG_N), .SEL_W(SEL_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
      .trig_lvl(trig_lvl), .trig_edge(trig_edge)
   );

   tmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .psc_sel(psc_sel),
      .opts(opts), .modulo(modulo), .trig_lvl(trig_lvl), .trig_edge(trig_edge),
      .dbg_mode(dbg_mode), .doze_mode(doze_mode), .flag_clr(flag_clr),
      .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
   );

   assign mode_ack = mode_eff;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              dbg_mode,
   input logic              doze_mode,
   input logic [CNT_W-1:0]  count,
   input logic              ovf_pulse,
   input logic              ovf_flag,
   input logic [1:0]        mode_ack,
   input opt_t              opts,
   input logic              trig_edge
);
   logic wr_ctrl, wr_clr, frozen;
   assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_clr  = wr_en && (wr_addr == ADDR_STAT) && wr_data[STAT_OVF_BIT];
   assign frozen  = (doze_mode && opts.doze_frz) || (dbg_mode && !opts.dbg_run);

   assert_off_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_ack == 2'd1 || mode_ack == 2'd2) |=> $stable(count));

   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> (count == '0 || count == $past(count) + CNT_W'(1)));

   assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> count == '0);

   assert_halt_after_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse && $past(opts.stop_on) && !trig_edge) |=> $stable(count));

   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !trig_edge) |=> $stable(count));

   assert_flag_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ovf_pulse);

   assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag) |-> $past(wr_clr));

   assert_mode_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ##1 (mode_ack == $past(wr_data[1:0], 2)));

endmodule

bind trig_mod_timer tmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_tmr_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .dbg_mode(dbg_mode), .doze_mode(doze_mode), .count(count), .ovf_pulse(ovf_pulse),
   .ovf_flag(ovf_flag), .mode_ack(mode_ack), .opts(opts), .trig_edge(trig_edge)
);

// File: tb/test_trig_mod_timer.sv
module test_trig_mod_timer;
   localparam int CNT_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        ext_clk = 1'b0;
   logic [15:0] trig_in = '0;
   logic        dbg_mode = 1'b0;
   logic        doze_mode = 1'b0;
   logic [CNT_W-1:0] count;
   logic        ovf_pulse, ovf_flag;
   logic [1:0]  mode_ack;

   int n_chk = 0, n_err = 0, n_pulse = 0;
   bit done = 0;
   string cur_req = "R1";

   trig_mod_timer i_trig_mod_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ext_clk(ext_clk), .trig_in(trig_in), .dbg_mode(dbg_mode), .doze_mode(doze_mode),
      .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag), .mode_ack(mode_ack)
   );

   always #4 clk = ~clk;   // 125 MHz

   // ---------------- behavioural reference model ----------------
   int m_ctl_mode = 0, m_eff = 0, m_psc = 0, m_sel = 0, m_mod = 0, m_cnt = 0, m_pc = 0;
   bit m_start = 0, m_reload = 0, m_stop = 0, m_pause = 0, m_dozef = 0, m_dbgr = 0;
   bit m_started = 0, m_halted = 0, m_prev = 0, m_pulse = 0, m_flag = 0;
   bit m_s0 = 0, m_s1 = 0, m_s2 = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl_mode = 0; m_eff = 0; m_psc = 0; m_sel = 0; m_mod = 0; m_cnt = 0; m_pc = 0;
         {m_start, m_reload, m_stop, m_pause, m_dozef, m_dbgr} = '0;
         {m_started, m_halted, m_prev, m_pulse, m_flag, m_s0, m_s1, m_s2} = '0;
      end else begin
         bit lvl, edge_s, act, tk, gate, reload, step, wrap, last;
         int div, md;
         lvl    = trig_in[m_sel];
         edge_s = lvl && !m_prev;
         act    = (m_eff == 1) || (m_eff == 2);
         tk     = (m_eff == 1) || (m_eff == 2 && m_s1 && !m_s2);
         div    = 1 << m_psc;
         last   = (m_pc % div) == div - 1;
         md     = (m_mod == 0) ? 1 : m_mod;
         gate   = (!m_start || m_started) && !m_halted
                  && !(doze_mode && m_dozef) && !(dbg_mode && !m_dbgr)
                  && !(m_pause && lvl);
         reload = act && m_reload && edge_s;
         step   = act && tk && gate && last && !reload;
         wrap   = step && (m_cnt >= md);
         if (reload || wrap) m_cnt = 0;
         else if (step)      m_cnt = m_cnt + 1;
         if (!act) begin
            m_pc = 0; m_started = 0; m_halted = 0;
         end else begin
            if (reload)        m_pc = 0;
            else if (tk && gate) m_pc = last ? 0 : (m_pc + 1) % 128;
            if (edge_s) m_started = 1;
            if (wrap && m_stop)          m_halted = 1;
            else if (edge_s && m_start)  m_halted = 0;
         end
         m_pulse = wrap;
         if (wrap) m_flag = 1;
         else if (wr_en && wr_addr == 2 && wr_data[8]) m_flag = 0;
         m_eff = m_ctl_mode;
         m_prev = lvl;
         m_s2 = m_s1; m_s1 = m_s0; m_s0 = ext_clk;
         if (wr_en && wr_addr == 0) begin
            m_ctl_mode = int'(wr_data[1:0]);
            m_psc      = int'(wr_data[4:2]);
            m_sel      = int'(wr_data[8:5]);
            {m_dbgr, m_dozef, m_pause, m_stop, m_reload, m_start} = wr_data[14:9];
         end
         if (wr_en && wr_addr == 1) m_mod = int'(wr_data[15:0]);
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         n_chk++;
         if (count !== CNT_W'(m_cnt) || ovf_pulse !== m_pulse ||
             ovf_flag !== m_flag || mode_ack !== 2'(m_eff)) begin
            n_err++;
            $display("FAIL %s cycle model: count=%0d/%0d pulse=%0b/%0b flag=%0b/%0b ack=%0d/%0d (actual/expected)",
                     cur_req, count, m_cnt, ovf_pulse, m_pulse, ovf_flag, m_flag, mode_ack, m_eff);
         end
         if (ovf_pulse) n_pulse++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [31:0] ctl(input int mode, input int psc, input int sel,
                                       input bit st, input bit rl, input bit sp,
                                       input bit pa, input bit dz, input bit dr);
      return 32'(mode) | (32'(psc) << 2) | (32'(sel) << 5) | (32'(st) << 9) |
             (32'(rl) << 10) | (32'(sp) << 11) | (32'(pa) << 12) |
             (32'(dz) << 13) | (32'(dr) << 14);
   endfunction

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic park;
      wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 0));
      cycles(3);
   endtask

   initial begin
      #800000;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int p0, c0;
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      cur_req = "R1";
      check(count == 0 && ovf_flag == 0 && ovf_pulse == 0, "R1 reset state", int'(count), 0);
      check(mode_ack == 0, "R12 reset ack", int'(mode_ack), 0);

      // R3 / R12: system clock, modulo 5
      cur_req = "R3";
      wr(2'd1, 32'd5);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 0));
      check(mode_ack == 0, "R12 ack before effect", int'(mode_ack), 0);
      cycles(1);
      check(mode_ack == 1, "R12 ack after effect", int'(mode_ack), 1);
      cycles(12);
      p0 = n_pulse; cycles(60);
      check(n_pulse - p0 == 10, "R3 wraps per 60 cycles, modulo 5", n_pulse - p0, 10);

      // R1: mode 0 holds count
      cur_req = "R1";
      wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 0));
      check(mode_ack == 1, "R12 ack still running", int'(mode_ack), 1);
      cycles(1);
      check(mode_ack == 0, "R12 ack shows stop", int'(mode_ack), 0);
      c0 = int'(count); cycles(10);
      check(int'(count) == c0, "R1 mode 0 holds", int'(count), c0);

      // R2: prescale by 8, modulo 3
      cur_req = "R2";
      wr(2'd1, 32'd3);
      wr(2'd0, ctl(1, 3, 0, 0, 0, 0, 0, 0, 0));
      cycles(40);
      p0 = n_pulse; cycles(128);
      check(n_pulse - p0 == 4, "R2 divide by 8 wraps", n_pulse - p0, 4);

      // R4: external clock, modulo 1
      cur_req = "R4";
      park();
      wr(2'd1, 32'd1);
      wr(2'd0, ctl(2, 0, 0, 0, 0, 0, 0, 0, 0));
      p0 = 0;
      for (int i = 0; i < 132; i++) begin
         @(negedge clk);
         if (i % 3 == 0) ext_clk = ~ext_clk;
         if (i == 12) p0 = n_pulse;
      end
      check(n_pulse - p0 == 10, "R4 external edges counted", n_pulse - p0, 10);
      cycles(5);
      c0 = int'(count); cycles(20);
      check(int'(count) == c0, "R4 steady ext clock no ticks", int'(count), c0);

      // R5: start on trigger, line 5 selected
      cur_req = "R5";
      park();
      wr(2'd1, 32'd100);
      wr(2'd0, ctl(1, 0, 5, 1, 0, 0, 0, 0, 0));
      cycles(10);
      c0 = int'(count);
      trig_in[4] = 1'b1; cycles(2); trig_in[4] = 1'b0; cycles(3);
      check(int'(count) == c0, "R5 waits, other line ignored", int'(count), c0);
      trig_in[5] = 1'b1; cycles(1); trig_in[5] = 1'b0; cycles(4);
      check(int'(count) == c0 + 4, "R5 counts after trigger", int'(count), c0 + 4);

      // R6: reload on trigger
      cur_req = "R6";
      wr(2'd0, ctl(1, 0, 5, 0, 1, 0, 0, 0, 0));
      cycles(20);
      p0 = n_pulse;
      trig_in[5] = 1'b1; cycles(1);
      check(count == 0, "R6 reload to zero", int'(count), 0);
      trig_in[5] = 1'b0; cycles(2);
      check(n_pulse == p0, "R6 reload gives no overflow", n_pulse, p0);

      // R7: pause while trigger high
      cur_req = "R7";
      wr(2'd0, ctl(1, 0, 5, 0, 0, 0, 1, 0, 0));
      cycles(5);
      trig_in[5] = 1'b1; cycles(1);
      c0 = int'(count); cycles(10);
      check(int'(count) == c0, "R7 paused while high", int'(count), c0);
      trig_in[5] = 1'b0; cycles(3);
      check(int'(count) == c0 + 3, "R7 resumes after release", int'(count), c0 + 3);

      // R8: stop after overflow
      cur_req = "R8";
      park();
      wr(2'd1, 32'd4);
      p0 = n_pulse;
      wr(2'd0, ctl(1, 0, 0, 0, 0, 1, 0, 0, 0));
      cycles(30);
      check(n_pulse - p0 == 1, "R8 single overflow", n_pulse - p0, 1);
      check(count == 0, "R8 halted at zero", int'(count), 0);

      // R9: doze and debug freeze
      cur_req = "R9";
      park();
      wr(2'd1, 32'd1000);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 1, 0));
      doze_mode = 1'b1; cycles(2);
      c0 = int'(count); cycles(10);
      check(int'(count) == c0, "R9 doze freeze", int'(count), c0);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 0));
      c0 = int'(count); cycles(4);
      check(int'(count) == c0 + 4, "R9 doze ignored when option clear", int'(count), c0 + 4);
      doze_mode = 1'b0; dbg_mode = 1'b1; cycles(2);
      c0 = int'(count); cycles(10);
      check(int'(count) == c0, "R9 debug freeze", int'(count), c0);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 1));
      c0 = int'(count); cycles(4);
      check(int'(count) == c0 + 4, "R9 debug run", int'(count), c0 + 4);
      dbg_mode = 1'b0;

      // R10: sticky flag and clear
      cur_req = "R10";
      park();
      check(ovf_flag == 1, "R10 flag sticky", int'(ovf_flag), 1);
      wr(2'd2, 32'h0FF);
      check(ovf_flag == 1, "R10 write without bit 8 ignored", int'(ovf_flag), 1);
      wr(2'd2, 32'h100);
      check(ovf_flag == 0, "R10 write bit 8 clears", int'(ovf_flag), 0);

      // R11: modulo 0 acts as 1
      cur_req = "R11";
      wr(2'd1, 32'd0);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 0));
      cycles(10);
      p0 = n_pulse; cycles(40);
      check(n_pulse - p0 == 20, "R11 modulo 0 wraps every 2", n_pulse - p0, 20);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule